// File: doc/BRIEF.md
# Ethernet Receive Alignment Error Counter

This block keeps one statistics count for a single Ethernet MAC receive port. It counts frames that end on a partial byte and also carry a bad frame check sequence. A frame is counted only when its length lies inside the legal window for that frame. The receive path reports each frame end as a summary on a one-cycle strobe. The summary holds:

- the length in whole bytes,
- a flag showing that leftover bits followed the last whole byte,
- an FCS error flag,
- a VLAN tag flag.

A jumbo configuration bit sits beside the summary. It is sampled with the strobe.

The frame-end strobe is a stream with no back-pressure. The block takes every strobe in the cycle it appears, so it has no ready signal, and the receive path may assert the strobe in any cycle, back to back. The count is read through a plain read port. A read request in one cycle returns the count one cycle later, with a valid flag. The same read also clears the count. The count is 32 bits wide. When it reaches all ones it holds there and does not wrap.

Top module: `rxae_rx_align_cnt`

## Requirements
- R1: A strobed frame with fcs_err=1, dribble=1 and a length inside the window increases the count by one.
- R2: A frame with fcs_err=0 is not counted.
- R3: A frame with dribble=0 is not counted, even with a bad FCS.
- R4: The lower bound of the window is 64 bytes. A length of 63 is not counted and a length of 64 is counted.
- R5: With jumbo=0 and vlan=0, the upper bound is 1518 bytes. A length of 1518 is counted and 1519 is not.
- R6: With jumbo=0 and vlan=1, the upper bound is 1522 bytes. A length of 1522 is counted and 1523 is not.
- R7: With jumbo=1, the upper bound is 2048 bytes whatever the vlan flag. A length of 2048 is counted and 2049 is not.
- R8: A frame whose whole-byte length equals the upper bound, with dribble=1, is counted. The partial byte does not push it past the bound.
- R9: The count saturates at all ones and does not wrap.
- R10: rd_en in cycle t gives rd_valid=1 in cycle t+1, and rd_data then carries the count as it stood in cycle t. The count becomes zero after the read.
- R11: After reset the count is 0.
- R12: If a qualifying frame and a read arrive in the same cycle, the read returns the count from before that frame and the count is 1 afterwards.
- R13: Each frame is evaluated only in the cycle its strobe is high. Flags presented while the strobe is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fe_valid_i | input | 1 | One-cycle strobe that marks a frame-end summary |
| fe_len_i | input | 12 | Frame length in whole bytes |
| fe_dribble_i | input | 1 | Leftover bits were seen after the last whole byte |
| fe_fcs_err_i | input | 1 | The frame check sequence was bad |
| fe_vlan_i | input | 1 | The frame carries a VLAN tag |
| cfg_jumbo_i | input | 1 | Raises the upper length bound to 2048 bytes |
| rd_en_i | input | 1 | Read request. The count is cleared by the read. |
| rd_valid_o | output | 1 | rd_data_o is valid in this cycle |
| rd_data_o | output | 32 | Count captured by the previous cycle's read |

## Verification
The assertions take two things for granted about the inputs:

- The summary fields are meaningful only while fe_valid_i is high.
- cfg_jumbo_i has the value that applies to the frame being strobed.

From these, the checker forms its own view of which frames qualify. The stimulus changes every input only on the falling clock edge. It holds each strobe for exactly one cycle, except in the cases that deliberately use back-to-back strobes or a strobe together with a read. It also sets lengths and flags while the strobe is low, to show that those values are ignored. A second instance with a 4-bit count reaches saturation in a few frames.

// File: rtl/rxae_pkg.sv
`timescale 1ns/1ps
package rxae_pkg;
  localparam int LEN_W         = 12;
  localparam int DEF_MIN_LEN   = 64;
  localparam int DEF_MAX_PLAIN = 1518;
  localparam int DEF_MAX_TAGGED = 1522;
  localparam int DEF_MAX_JUMBO = 2048;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             dribble;
    logic             fcs_err;
    logic             vlan;
  } frame_sum_t;
endpackage

// File: rtl/rxae_len_limit.sv
`timescale 1ns/1ps
module rxae_len_limit
  import rxae_pkg::*;
#(
  parameter int MAX_PLAIN  = DEF_MAX_PLAIN,
  parameter int MAX_TAGGED = DEF_MAX_TAGGED,
  parameter int MAX_JUMBO  = DEF_MAX_JUMBO
) (
  input  logic             vlan_i,
  input  logic             jumbo_i,
  output logic [LEN_W-1:0] max_len_o
);
  localparam logic [LEN_W-1:0] LIM_PLAIN  = LEN_W'(MAX_PLAIN);
  localparam logic [LEN_W-1:0] LIM_TAGGED = LEN_W'(MAX_TAGGED);
  localparam logic [LEN_W-1:0] LIM_JUMBO  = LEN_W'(MAX_JUMBO);

  // The jumbo setting takes priority over the tag flag.
  always_comb begin
    if (jumbo_i)     max_len_o = LIM_JUMBO;
    else if (vlan_i) max_len_o = LIM_TAGGED;
    else             max_len_o = LIM_PLAIN;
  end
endmodule

// File: rtl/rxae_qualify.sv
`timescale 1ns/1ps
module rxae_qualify
  import rxae_pkg::*;
#(
  parameter int MIN_LEN = DEF_MIN_LEN
) (
  input  logic             valid_i,
  input  frame_sum_t       sum_i,
  input  logic [LEN_W-1:0] max_len_i,
  output logic             hit_o
);
  localparam logic [LEN_W-1:0] LIM_MIN = LEN_W'(MIN_LEN);

  logic above_min, below_max, flags_ok;

  // The length is counted in whole bytes only. A frame that sits exactly
  // at the bound and has a partial byte after it stays inside the window.
  assign above_min = (sum_i.len >= LIM_MIN);
  assign below_max = (sum_i.len <= max_len_i);
  assign flags_ok  = sum_i.fcs_err & sum_i.dribble;
  assign hit_o     = valid_i & flags_ok & above_min & below_max;
endmodule

// File: rtl/rxae_sat_cnt.sv
`timescale 1ns/1ps
module rxae_sat_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             rd_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rd_valid_o,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  // A read clears the count. An event in the same cycle as the read
  // becomes the first unit of the new count.
  always_comb begin
    cnt_d = cnt_q;
    if (rd_en_i)              cnt_d = inc_i ? CNT_ONE : '0;
    else if (inc_i && !at_max) cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      cnt_q      <= cnt_d;
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= cnt_q;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rxae_rx_align_cnt.sv
`timescale 1ns/1ps
module rxae_rx_align_cnt
  import rxae_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int MIN_LEN    = DEF_MIN_LEN,
  parameter int MAX_PLAIN  = DEF_MAX_PLAIN,
  parameter int MAX_TAGGED = DEF_MAX_TAGGED,
  parameter int MAX_JUMBO  = DEF_MAX_JUMBO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fe_valid_i,
  input  logic [LEN_W-1:0] fe_len_i,
  input  logic             fe_dribble_i,
  input  logic             fe_fcs_err_i,
  input  logic             fe_vlan_i,
  input  logic             cfg_jumbo_i,
  input  logic             rd_en_i,
  output logic             rd_valid_o,
  output logic [CNT_W-1:0] rd_data_o
);
  frame_sum_t       sum;
  logic [LEN_W-1:0] max_len;
  logic             hit;
  logic [CNT_W-1:0] cnt_val;

  assign sum = '{len: fe_len_i, dribble: fe_dribble_i,
                 fcs_err: fe_fcs_err_i, vlan: fe_vlan_i};

  rxae_len_limit #(
    .MAX_PLAIN (MAX_PLAIN),
    .MAX_TAGGED(MAX_TAGGED),
    .MAX_JUMBO (MAX_JUMBO)
  ) limit_i (
    .vlan_i   (fe_vlan_i),
    .jumbo_i  (cfg_jumbo_i),
    .max_len_o(max_len)
  );

  rxae_qualify #(.MIN_LEN(MIN_LEN)) qual_i (
    .valid_i  (fe_valid_i),
    .sum_i    (sum),
    .max_len_i(max_len),
    .hit_o    (hit)
  );

  rxae_sat_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (hit),
    .rd_en_i   (rd_en_i),
    .cnt_o     (cnt_val),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/rxae_chk.sv
`timescale 1ns/1ps
module rxae_chk
  import rxae_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fe_valid_i,
  input logic [LEN_W-1:0] fe_len_i,
  input logic             fe_dribble_i,
  input logic             fe_fcs_err_i,
  input logic             rd_en_i,
  input logic             rd_valid_o,
  input logic [CNT_W-1:0] rd_data_o,
  input logic [CNT_W-1:0] cnt_val
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic cannot_count;
  assign cannot_count = !fe_valid_i || !fe_fcs_err_i || !fe_dribble_i ||
                        (fe_len_i < LEN_W'(DEF_MIN_LEN)) ||
                        (fe_len_i > LEN_W'(DEF_MAX_JUMBO));

  // R2
  no_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i && cannot_count) |=> $stable(cnt_val));

  // R9
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i && cnt_val == ALL_ONES) |=> (cnt_val == ALL_ONES));

  // R10
  rd_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rd_valid_o && rd_data_o == $past(cnt_val)));

  // R10
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && cannot_count) |=> (cnt_val == '0));

  // R12
  rd_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (cnt_val <= CNT_W'(1)));

  // R1
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (cnt_val - $past(cnt_val) <= CNT_W'(1)));

  // R10
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
endmodule

bind rxae_rx_align_cnt rxae_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fe_valid_i  (fe_valid_i),
  .fe_len_i    (fe_len_i),
  .fe_dribble_i(fe_dribble_i),
  .fe_fcs_err_i(fe_fcs_err_i),
  .rd_en_i     (rd_en_i),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .cnt_val     (cnt_val)
);

// File: tb/rxae_rx_align_cnt_tb_top.sv
`timescale 1ns/1ps
module rxae_rx_align_cnt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fe_valid = 1'b0;
  logic [11:0] fe_len = '0;
  logic        fe_drib = 1'b0;
  logic        fe_fcs = 1'b0;
  logic        fe_vlan = 1'b0;
  logic        jumbo = 1'b0;
  logic        rd_en = 1'b0;
  logic        rd_valid, sat_valid;
  logic [31:0] rd_data;
  logic [3:0]  sat_data;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R11";

  always #5 clk = ~clk;

  rxae_rx_align_cnt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fe_valid_i(fe_valid), .fe_len_i(fe_len),
    .fe_dribble_i(fe_drib), .fe_fcs_err_i(fe_fcs), .fe_vlan_i(fe_vlan),
    .cfg_jumbo_i(jumbo), .rd_en_i(rd_en), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data));

  rxae_rx_align_cnt #(.CNT_W(4)) sat_i (
    .clk_i(clk), .rst_ni(rst_n), .fe_valid_i(fe_valid), .fe_len_i(fe_len),
    .fe_dribble_i(fe_drib), .fe_fcs_err_i(fe_fcs), .fe_vlan_i(fe_vlan),
    .cfg_jumbo_i(jumbo), .rd_en_i(rd_en), .rd_valid_o(sat_valid),
    .rd_data_o(sat_data));

  // Reference model, written from the requirements.
  longint m_cnt = 0, m_sat = 0, e_data = 0, e_sat = 0;
  bit     e_valid = 0;

  function automatic bit qualifies();
    int lim;
    lim = jumbo ? 2048 : (fe_vlan ? 1522 : 1518);
    return fe_valid && fe_fcs && fe_drib && fe_len >= 64 && int'(fe_len) <= lim;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sat = 0; e_valid = 0; e_data = 0; e_sat = 0;
    end else begin
      bit q;
      q = qualifies();
      e_valid = rd_en;
      if (rd_en) begin
        e_data = m_cnt; e_sat = m_sat;
        m_cnt = q ? 1 : 0; m_sat = q ? 1 : 0;
      end else if (q) begin
        if (m_cnt < 64'hFFFF_FFFF) m_cnt++;
        if (m_sat < 15) m_sat++;
      end
    end
  end

  task automatic check(string req, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare on every clock, shortly after the edge.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(cur_req, rd_valid, e_valid, "rd_valid");
      check(cur_req, sat_valid, e_valid, "sat rd_valid");
      if (e_valid) begin
        check(cur_req, rd_data, e_data, "rd_data");
        check(cur_req, sat_data, e_sat, "sat rd_data");
      end
    end
  end

  task automatic frame(int len, bit d, bit f, bit v, bit j);
    @(negedge clk);
    fe_valid = 1; fe_len = 12'(len); fe_drib = d; fe_fcs = f;
    fe_vlan = v; jumbo = j;
    @(negedge clk);
    fe_valid = 0;
  endtask

  task automatic do_read(string req, longint exp);
    @(negedge clk);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    check(req, rd_data, exp, "read value");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R11"; do_read("R11", 0);

    cur_req = "R1";  frame(500, 1, 1, 0, 0); frame(900, 1, 1, 1, 0);
    do_read("R1", 2);
    cur_req = "R2";  frame(500, 1, 0, 0, 0); do_read("R2", 0);
    cur_req = "R3";  frame(500, 0, 1, 0, 0); do_read("R3", 0);
    cur_req = "R4";  frame(63, 1, 1, 0, 0); do_read("R4", 0);
    frame(64, 1, 1, 0, 0); do_read("R4", 1);
    cur_req = "R5";  frame(1519, 1, 1, 0, 0); do_read("R5", 0);
    frame(1518, 1, 1, 0, 0); do_read("R5", 1);
    cur_req = "R6";  frame(1523, 1, 1, 1, 0); do_read("R6", 0);
    frame(1522, 1, 1, 1, 0); do_read("R6", 1);
    cur_req = "R7";  frame(2048, 1, 1, 0, 1); frame(2048, 1, 1, 1, 1);
    frame(2049, 1, 1, 1, 1); frame(4000, 1, 1, 0, 1); do_read("R7", 2);
    cur_req = "R8";  frame(1518, 1, 1, 0, 0); frame(1522, 1, 1, 1, 0);
    do_read("R8", 2);

    cur_req = "R13";
    @(negedge clk);
    fe_len = 12'd700; fe_drib = 1; fe_fcs = 1; jumbo = 0; fe_vlan = 0;
    repeat (4) @(negedge clk);
    do_read("R13", 0);
    @(negedge clk); fe_valid = 1;
    repeat (3) @(negedge clk);
    fe_valid = 0;
    do_read("R13", 3);

    cur_req = "R12";
    frame(300, 1, 1, 0, 0); frame(300, 1, 1, 0, 0);
    @(negedge clk);
    fe_valid = 1; rd_en = 1;
    @(negedge clk);
    fe_valid = 0; rd_en = 0;
    check("R12", rd_data, 2, "read with coincident frame");
    do_read("R12", 1);

    cur_req = "R9";
    for (int i = 0; i < 20; i++) frame(200, 1, 1, 0, 0);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    check("R9", sat_data, 15, "saturated 4-bit read");
    check("R9", rd_data, 20, "wide read");
    cur_req = "R10"; do_read("R10", 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule